// File: doc/BRIEF.md
# Input Overcurrent Warning Monitor with Event Log

The block watches a stream of input-current telemetry samples and compares each valid sample against a programmable warning threshold. When a sample is strictly above the threshold, it latches a sticky warning. The warning shows up at three levels of status registers and drives an active-low alert pin unless a mask input suppresses it. The first sample of each warning episode also records an event entry into a small circular log. Each entry holds an event code and the value of a free-running relative timestamp.

The warning is released only by a clear-faults strobe, and only when the most recent sample is no longer above the threshold. A new episode can then start. The threshold sits in a 16-bit register of which only the low 8 bits carry meaning. Writes to it are accepted only while a write-protect unlock input is high. A log-clear input frees every log slot and returns the log pointer to slot 0. A combinational read port exposes any slot.

Top module: `ocw_monitor`

## Requirements
- R1: After reset the threshold reads 0x007F, all status outputs read zero, `alert_n` is 1, `log_ptr` is 0, `log_valid` is all zero and `ts_value` is 0.
- R2: A cycle with `thr_wr_en` and `wp_unlock` both high loads the threshold. From the next cycle `thr_value` reads `{8'h00, thr_wr_data[7:0]}`, so the upper byte of written data is discarded.
- R3: A threshold write with `wp_unlock` low is ignored, and `thr_value` keeps its previous value.
- R4: A valid sample strictly greater than the low 8 bits of the threshold sets, from the next cycle, `status_byte` bit 0, `status_word` bit 13 and `status_input` bit 5. The low byte of `status_word` mirrors `status_byte`, and a sample equal to the threshold sets nothing.
- R5: `alert_n` is 0 while the warning is latched and `alert_mask` is 0. It is 1 whenever `alert_mask` is 1 or no warning is latched.
- R6: A `clear_faults` strobe releases the warning (and the alert) only if the most recent valid sample before that cycle was not above the threshold. Otherwise it has no effect. A valid over-threshold sample in the same cycle as an accepted clear starts a new episode.
- R7: A warning that persists over many over-threshold samples produces one log event only, at the start of the episode.
- R8: On an event, if the slot selected by `log_ptr` has its valid bit clear, that slot receives code 0xA5 and the timestamp, its valid bit is set, and `log_ptr` advances by one, going from 6 back to 0. If the slot is occupied, nothing is written and `log_ptr` is unchanged.
- R9: `log_clear` clears every valid bit and sets `log_ptr` to 0 on the next cycle, and it takes priority over an event in the same cycle.
- R10: `ts_value` increments by one on each cycle with `ts_tick` high and wraps to 0 after its all-ones value. The timestamp logged for an event is the value before that cycle's tick.
- R11: `log_rd_code` and `log_rd_ts` combinationally show the slot selected by `log_rd_idx`, or zero for an index at or beyond the log depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_unlock | input | 1 | High permits threshold writes |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | THR_W | Threshold write data |
| smp_valid | input | 1 | Telemetry sample valid |
| smp_data | input | SMP_W | Telemetry current sample |
| clear_faults | input | 1 | Clear-faults strobe |
| alert_mask | input | 1 | Suppresses the alert when high |
| ts_tick | input | 1 | Prescaled timestamp advance |
| log_clear | input | 1 | Frees all log slots, pointer to 0 |
| log_rd_idx | input | PTR_W | Log slot selected for reading |
| thr_value | output | THR_W | Current threshold register |
| status_byte | output | 8 | Summary status, bit 0 = other warning |
| status_word | output | 16 | Bit 13 = input status, low byte = status_byte |
| status_input | output | 8 | Input status, bit 5 = overcurrent warning |
| alert_n | output | 1 | Active-low alert |
| ts_value | output | TS_W | Relative timestamp counter |
| log_ptr | output | PTR_W | Next log slot |
| log_valid | output | LOG_DEPTH | Slot occupied flags |
| log_rd_code | output | EVT_W | Event code of the selected slot |
| log_rd_ts | output | TS_W | Timestamp of the selected slot |

## Verification
The bench keeps the default 8-bit meaningful threshold, 10-bit samples and seven log slots, but narrows the timestamp to 8 bits. This lets counter wraparound occur many times within a few thousand cycles, and lets logged timestamps from both sides of a wrap reach the read port. The 10-bit samples reach values far above any 8-bit threshold as well as values just around it, which exercises the strict comparison at both ends. Seven slots keep the pointer wrap from 6 to 0 and the full-log case within a handful of directed episodes.

// File: rtl/ocw_pkg.sv
package ocw_pkg;
   // Status bit positions decoded by the surrounding status logic
   localparam int SB_OTHER_BIT  = 0;
   localparam int SW_INPUT_BIT  = 13;
   localparam int SI_OCW_BIT    = 5;
   // Event code written into the log for an overcurrent warning
   localparam logic [7:0] EVT_OCW_CODE = 8'hA5;

   // Circular increment used by the log pointer
   function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
      return (p >= depth - 1) ? 0 : p + 1;
   endfunction
endpackage

// File: rtl/ocw_thr_reg.sv
module ocw_thr_reg #(
   parameter int              THR_W     = 16,
   parameter int              THR_BITS  = 8,
   parameter logic [THR_W-1:0] THR_RESET = 16'h007F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             unlock,
   input  logic [THR_W-1:0] wr_data,
   output logic [THR_W-1:0] thr_q
);
   localparam int PAD_W = THR_W - THR_BITS;

   logic [THR_W-1:0] wr_masked;

   generate
      if (PAD_W > 0) begin : g_pad
         assign wr_masked = {{PAD_W{1'b0}}, wr_data[THR_BITS-1:0]};
      end else begin : g_nopad
         assign wr_masked = wr_data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q <= THR_RESET;
      end else if (wr_en && unlock) begin
         thr_q <= wr_masked;
      end
   end
endmodule

// File: rtl/ocw_detect.sv
module ocw_detect #(
   parameter int SMP_W    = 10,
   parameter int THR_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [SMP_W-1:0]    smp_data,
   input  logic [THR_BITS-1:0] thr_bits,
   input  logic                clear_faults,
   output logic                warn_q,
   output logic                evt
);
   logic over_q;
   logic cmp;
   logic clr_ok;

   assign cmp    = smp_data > SMP_W'(thr_bits);
   assign clr_ok = clear_faults & ~over_q;
   // clear is applied first, then the sample of the same cycle
   assign evt    = smp_valid & cmp & ~(warn_q & ~clr_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         over_q <= 1'b0;
         warn_q <= 1'b0;
      end else begin
         if (smp_valid) over_q <= cmp;
         warn_q <= evt | (warn_q & ~clr_ok);
      end
   end
endmodule

// File: rtl/ocw_ts_counter.sv
module ocw_ts_counter #(
   parameter int TS_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   output logic [TS_W-1:0] ts_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ts_q <= '0;
      else if (tick) ts_q <= ts_q + TS_W'(1);
   end
endmodule

// File: rtl/ocw_event_log.sv
module ocw_event_log #(
   parameter int DEPTH = 7,
   parameter int EVT_W = 8,
   parameter int TS_W  = 16,
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             log_clear,
   input  logic             evt,
   input  logic [EVT_W-1:0] evt_code,
   input  logic [TS_W-1:0]  evt_ts,
   input  logic [PTR_W-1:0] rd_idx,
   output logic [PTR_W-1:0] ptr_q,
   output logic [DEPTH-1:0] vld_q,
   output logic [EVT_W-1:0] rd_code,
   output logic [TS_W-1:0]  rd_ts
);
   logic             do_wr;
   logic [PTR_W-1:0] ptr_nxt;
   logic [EVT_W-1:0] code_arr [DEPTH];
   logic [TS_W-1:0]  ts_arr   [DEPTH];

   assign do_wr   = evt & ~log_clear & ~vld_q[ptr_q];
   assign ptr_nxt = PTR_W'(ocw_pkg::wrap_inc(int'(ptr_q), DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         vld_q <= '0;
      end else if (log_clear) begin
         ptr_q <= '0;
         vld_q <= '0;
      end else if (do_wr) begin
         ptr_q        <= ptr_nxt;
         vld_q[ptr_q] <= 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [EVT_W-1:0] code_r;
         logic [TS_W-1:0]  ts_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               code_r <= '0;
               ts_r   <= '0;
            end else if (do_wr && (ptr_q == PTR_W'(i))) begin
               code_r <= evt_code;
               ts_r   <= evt_ts;
            end
         end
         assign code_arr[i] = code_r;
         assign ts_arr[i]   = ts_r;
      end
   endgenerate

   always_comb begin
      rd_code = '0;
      rd_ts   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx == PTR_W'(i)) begin
            rd_code = code_arr[i];
            rd_ts   = ts_arr[i];
         end
      end
   end
endmodule

// File: rtl/ocw_monitor.sv
module ocw_monitor #(
   parameter int               THR_W     = 16,
   parameter int               THR_BITS  = 8,
   parameter logic [THR_W-1:0] THR_RESET = 16'h007F,
   parameter int               SMP_W     = 10,
   parameter int               TS_W      = 16,
   parameter int               LOG_DEPTH = 7,
   parameter int               EVT_W     = 8,
   parameter logic [EVT_W-1:0] EVT_CODE  = ocw_pkg::EVT_OCW_CODE,
   localparam int              PTR_W     = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wp_unlock,
   input  logic                 thr_wr_en,
   input  logic [THR_W-1:0]     thr_wr_data,
   input  logic                 smp_valid,
   input  logic [SMP_W-1:0]     smp_data,
   input  logic                 clear_faults,
   input  logic                 alert_mask,
   input  logic                 ts_tick,
   input  logic                 log_clear,
   input  logic [PTR_W-1:0]     log_rd_idx,
   output logic [THR_W-1:0]     thr_value,
   output logic [7:0]           status_byte,
   output logic [15:0]          status_word,
   output logic [7:0]           status_input,
   output logic                 alert_n,
   output logic [TS_W-1:0]      ts_value,
   output logic [PTR_W-1:0]     log_ptr,
   output logic [LOG_DEPTH-1:0] log_valid,
   output logic [EVT_W-1:0]     log_rd_code,
   output logic [TS_W-1:0]      log_rd_ts
);
   generate
      if (THR_BITS < 1 || THR_BITS > THR_W) begin : g_bad_thr
         $error("ocw_monitor: THR_BITS must lie in 1..THR_W");
      end
      if (SMP_W < THR_BITS) begin : g_bad_smp
         $error("ocw_monitor: SMP_W must be at least THR_BITS");
      end
      if (LOG_DEPTH < 2) begin : g_bad_depth
         $error("ocw_monitor: LOG_DEPTH must be at least 2");
      end
      if (TS_W < 1) begin : g_bad_ts
         $error("ocw_monitor: TS_W must be positive");
      end
   endgenerate

   logic warn_q;
   logic evt;

   ocw_thr_reg #(
      .THR_W    (THR_W),
      .THR_BITS (THR_BITS),
      .THR_RESET(THR_RESET)
   ) u_thr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (thr_wr_en),
      .unlock (wp_unlock),
      .wr_data(thr_wr_data),
      .thr_q  (thr_value)
   );

   ocw_detect #(
      .SMP_W   (SMP_W),
      .THR_BITS(THR_BITS)
   ) u_det (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_valid   (smp_valid),
      .smp_data    (smp_data),
      .thr_bits    (thr_value[THR_BITS-1:0]),
      .clear_faults(clear_faults),
      .warn_q      (warn_q),
      .evt         (evt)
   );

   ocw_ts_counter #(.TS_W(TS_W)) u_ts (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (ts_tick),
      .ts_q (ts_value)
   );

   ocw_event_log #(
      .DEPTH(LOG_DEPTH),
      .EVT_W(EVT_W),
      .TS_W (TS_W),
      .PTR_W(PTR_W)
   ) u_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .log_clear(log_clear),
      .evt      (evt),
      .evt_code (EVT_CODE),
      .evt_ts   (ts_value),
      .rd_idx   (log_rd_idx),
      .ptr_q    (log_ptr),
      .vld_q    (log_valid),
      .rd_code  (log_rd_code),
      .rd_ts    (log_rd_ts)
   );

   always_comb begin
      status_byte                        = '0;
      status_byte[ocw_pkg::SB_OTHER_BIT] = warn_q;
      status_input                       = '0;
      status_input[ocw_pkg::SI_OCW_BIT]  = warn_q;
      status_word                        = {8'h00, status_byte};
      status_word[ocw_pkg::SW_INPUT_BIT] = warn_q;
   end

   assign alert_n = ~(warn_q & ~alert_mask);
endmodule

// File: rtl/ocw_monitor_chk.sv
module ocw_monitor_chk #(
   parameter int THR_W     = 16,
   parameter int THR_BITS  = 8,
   parameter int SMP_W     = 10,
   parameter int TS_W      = 16,
   parameter int LOG_DEPTH = 7,
   parameter int PTR_W     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wp_unlock,
   input logic                 thr_wr_en,
   input logic [THR_W-1:0]     thr_value,
   input logic                 smp_valid,
   input logic [SMP_W-1:0]     smp_data,
   input logic                 clear_faults,
   input logic                 alert_mask,
   input logic                 alert_n,
   input logic [7:0]           status_input,
   input logic                 ts_tick,
   input logic [TS_W-1:0]      ts_value,
   input logic                 log_clear,
   input logic [PTR_W-1:0]     log_ptr,
   input logic [LOG_DEPTH-1:0] log_valid
);
   logic over_now;
   logic warn_bit;
   assign over_now = smp_valid && (smp_data > SMP_W'(thr_value[THR_BITS-1:0]));
   assign warn_bit = status_input[ocw_pkg::SI_OCW_BIT];

   a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_value >> THR_BITS) == '0);

   a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr_en && !wp_unlock) |=> $stable(thr_value));

   a_r4_over_sets: assert property (@(posedge clk) disable iff (!rst_n)
      over_now |=> warn_bit);

   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (warn_bit && !clear_faults) |=> warn_bit);

   a_r5_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      alert_mask |-> alert_n);

   a_r8_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(log_ptr) < LOG_DEPTH);

   a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!log_clear && (log_ptr != $past(log_ptr)) && !$past(log_clear)) |->
      (int'(log_ptr) == int'(ocw_pkg::wrap_inc(int'($past(log_ptr)), LOG_DEPTH))));

   a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      log_clear |=> (log_valid == '0 && log_ptr == '0));

   a_r10_ts_step: assert property (@(posedge clk) disable iff (!rst_n)
      ts_tick |=> (ts_value == TS_W'($past(ts_value) + 1'b1)));

   a_r10_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ts_tick |=> $stable(ts_value));
endmodule

bind ocw_monitor ocw_monitor_chk #(
   .THR_W    (THR_W),
   .THR_BITS (THR_BITS),
   .SMP_W    (SMP_W),
   .TS_W     (TS_W),
   .LOG_DEPTH(LOG_DEPTH),
   .PTR_W    (PTR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wp_unlock   (wp_unlock),
   .thr_wr_en   (thr_wr_en),
   .thr_value   (thr_value),
   .smp_valid   (smp_valid),
   .smp_data    (smp_data),
   .clear_faults(clear_faults),
   .alert_mask  (alert_mask),
   .alert_n     (alert_n),
   .status_input(status_input),
   .ts_tick     (ts_tick),
   .ts_value    (ts_value),
   .log_clear   (log_clear),
   .log_ptr     (log_ptr),
   .log_valid   (log_valid)
);

// File: tb/ocw_monitor_test.sv
module ocw_monitor_test;
   localparam int CLK_P  = 10;
   localparam int THR_W  = 16;
   localparam int SMP_W  = 10;
   localparam int TS_W   = 8;
   localparam int DEPTH  = 7;
   localparam int PTR_W  = 3;
   localparam int EVT_W  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wp_unlock = 1'b0, thr_wr_en = 1'b0;
   logic [THR_W-1:0] thr_wr_data = '0;
   logic smp_valid = 1'b0;
   logic [SMP_W-1:0] smp_data = '0;
   logic clear_faults = 1'b0, alert_mask = 1'b0, ts_tick = 1'b0, log_clear = 1'b0;
   logic [PTR_W-1:0] log_rd_idx = '0;
   logic [THR_W-1:0] thr_value;
   logic [7:0] status_byte, status_input;
   logic [15:0] status_word;
   logic alert_n;
   logic [TS_W-1:0] ts_value;
   logic [PTR_W-1:0] log_ptr;
   logic [DEPTH-1:0] log_valid;
   logic [EVT_W-1:0] log_rd_code;
   logic [TS_W-1:0] log_rd_ts;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // reference state
   logic [THR_W-1:0] m_thr;
   bit m_over, m_warn;
   logic [DEPTH-1:0] m_valid;
   int m_ptr;
   logic [TS_W-1:0] m_ts;
   logic [EVT_W-1:0] m_code [DEPTH];
   logic [TS_W-1:0] m_lts [DEPTH];

   always #(CLK_P/2) clk = ~clk;

   ocw_monitor #(.SMP_W(SMP_W), .TS_W(TS_W), .LOG_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .wp_unlock(wp_unlock), .thr_wr_en(thr_wr_en),
      .thr_wr_data(thr_wr_data), .smp_valid(smp_valid), .smp_data(smp_data),
      .clear_faults(clear_faults), .alert_mask(alert_mask), .ts_tick(ts_tick),
      .log_clear(log_clear), .log_rd_idx(log_rd_idx), .thr_value(thr_value),
      .status_byte(status_byte), .status_word(status_word), .status_input(status_input),
      .alert_n(alert_n), .ts_value(ts_value), .log_ptr(log_ptr), .log_valid(log_valid),
      .log_rd_code(log_rd_code), .log_rd_ts(log_rd_ts));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_thr = 16'h007F; m_over = 0; m_warn = 0; m_valid = '0; m_ptr = 0; m_ts = '0;
      for (int i = 0; i < DEPTH; i++) begin m_code[i] = '0; m_lts[i] = '0; end
   endtask

   task automatic model_step();
      bit over_now, clr_ok, evt;
      if (!rst_n) begin model_reset(); return; end
      over_now = smp_valid && (smp_data > SMP_W'(m_thr[7:0]));
      clr_ok   = clear_faults && !m_over;
      evt      = over_now && !(m_warn && !clr_ok);
      m_warn   = evt || (m_warn && !clr_ok);
      if (smp_valid) m_over = (smp_data > SMP_W'(m_thr[7:0]));
      if (log_clear) begin
         m_valid = '0; m_ptr = 0;
      end else if (evt && !m_valid[m_ptr]) begin
         m_code[m_ptr] = 8'hA5; m_lts[m_ptr] = m_ts; m_valid[m_ptr] = 1'b1;
         m_ptr = (m_ptr == DEPTH-1) ? 0 : m_ptr + 1;
      end
      if (thr_wr_en && wp_unlock) m_thr = {8'h00, thr_wr_data[7:0]};
      if (ts_tick) m_ts = m_ts + 1'b1;
   endtask

   task automatic compare_all();
      int idx = int'(log_rd_idx);
      logic [EVT_W-1:0] ec = (idx < DEPTH) ? m_code[idx] : '0;
      logic [TS_W-1:0]  et = (idx < DEPTH) ? m_lts[idx]  : '0;
      chk(thr_value == m_thr, "R2 threshold", 32'(thr_value), 32'(m_thr));
      chk(status_input == (8'(m_warn) << 5), "R4 status_input", 32'(status_input), 32'(8'(m_warn) << 5));
      chk(status_byte == 8'(m_warn), "R4 status_byte", 32'(status_byte), 32'(m_warn));
      chk(status_word == ((16'(m_warn) << 13) | 16'(m_warn)), "R4 status_word",
          32'(status_word), 32'((16'(m_warn) << 13) | 16'(m_warn)));
      chk(alert_n == !(m_warn && !alert_mask), "R5 alert_n", 32'(alert_n), 32'(!(m_warn && !alert_mask)));
      chk(int'(log_ptr) == m_ptr, "R8 log_ptr", 32'(log_ptr), 32'(m_ptr));
      chk(log_valid == m_valid, "R8 log_valid", 32'(log_valid), 32'(m_valid));
      chk(ts_value == m_ts, "R10 ts_value", 32'(ts_value), 32'(m_ts));
      chk(log_rd_code == ec, "R11 rd_code", 32'(log_rd_code), 32'(ec));
      chk(log_rd_ts == et, "R11 rd_ts", 32'(log_rd_ts), 32'(et));
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      wp_unlock = 0; thr_wr_en = 0; smp_valid = 0; clear_faults = 0;
      ts_tick = 0; log_clear = 0;
   endtask

   task automatic sample(input int v);
      idle(); smp_valid = 1; smp_data = SMP_W'(v); cyc(); smp_valid = 0;
   endtask

   // one full episode: over sample, under sample, clear
   task automatic episode();
      sample(int'(m_thr[7:0]) + 5);
      sample(0);
      idle(); clear_faults = 1; cyc(); clear_faults = 0;
   endtask

   initial begin
      void'($urandom(32'd20250611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(thr_value == 16'h007F, "R1 thr reset", 32'(thr_value), 32'h7F);
      chk(status_byte == 0 && status_word == 0 && status_input == 0, "R1 status reset",
          32'(status_word), 0);
      chk(alert_n == 1'b1, "R1 alert reset", 32'(alert_n), 1);
      chk(log_ptr == 0 && log_valid == 0 && ts_value == 0, "R1 log/ts reset",
          32'({log_ptr, log_valid}), 0);
      compare_all();

      // R3 locked write ignored
      idle(); thr_wr_en = 1; thr_wr_data = 16'h1234; cyc();
      chk(thr_value == 16'h007F, "R3 locked write", 32'(thr_value), 32'h7F);
      // R2 unlocked write drops upper byte
      idle(); thr_wr_en = 1; wp_unlock = 1; thr_wr_data = 16'hAB40; cyc();
      chk(thr_value == 16'h0040, "R2 unlocked write", 32'(thr_value), 32'h40);
      // R4 equal sample does nothing
      sample(16'h40);
      chk(status_input == 0, "R4 equal no warn", 32'(status_input), 0);
      // R4 strictly above sets all levels
      idle(); ts_tick = 1; cyc();
      sample(16'h41);
      chk(status_input == 8'h20 && status_byte == 8'h01 && status_word == 16'h2001,
          "R4 warn levels", 32'(status_word), 32'h2001);
      chk(alert_n == 0, "R5 alert active", 32'(alert_n), 0);
      log_rd_idx = 0; #1;
      chk(log_rd_code == 8'hA5 && log_rd_ts == 8'd1, "R8 first entry",
          32'({log_rd_code, log_rd_ts}), 32'hA501);
      // R7 persistent over samples: no further entries
      for (int k = 0; k < 5; k++) sample(16'h3FF);
      chk(log_ptr == 1 && log_valid == 7'h01, "R7 single event", 32'(log_ptr), 1);
      // R6 clear while still over is ignored
      idle(); clear_faults = 1; cyc(); clear_faults = 0;
      chk(status_input == 8'h20, "R6 clear ignored while over", 32'(status_input), 32'h20);
      sample(16'h10);
      idle(); clear_faults = 1; cyc(); clear_faults = 0;
      chk(status_input == 0 && alert_n == 1, "R6 clear accepted", 32'(status_input), 0);
      // R5 masked alert
      alert_mask = 1;
      sample(16'h80);
      chk(alert_n == 1 && status_input == 8'h20, "R5 masked", 32'(alert_n), 1);
      sample(0);
      idle(); clear_faults = 1; cyc();
      alert_mask = 0;
      // R8 fill remaining slots, wrap pointer
      for (int k = 0; k < 5; k++) episode();
      chk(log_ptr == 0 && log_valid == 7'h7F, "R8 pointer wrap", 32'(log_ptr), 0);
      // R8 full log: event leaves pointer and slots alone
      episode();
      chk(log_ptr == 0 && log_valid == 7'h7F, "R8 full log", 32'(log_valid), 32'h7F);
      // R9 log clear
      idle(); log_clear = 1; cyc(); log_clear = 0;
      chk(log_ptr == 0 && log_valid == 0, "R9 log clear", 32'(log_valid), 0);
      // R9 clear beats simultaneous event
      idle(); smp_valid = 1; smp_data = 10'h3FF; log_clear = 1; cyc();
      chk(log_valid == 0, "R9 clear priority", 32'(log_valid), 0);
      sample(0);
      idle(); clear_faults = 1; cyc();
      // R11 out-of-range read index
      log_rd_idx = 3'd7; #1;
      chk(log_rd_code == 0 && log_rd_ts == 0, "R11 out of range", 32'(log_rd_code), 0);

      // constrained random phase
      for (int n = 0; n < 4000; n++) begin
         int r = int'($urandom % 100);
         int base = int'(m_thr[7:0]);
         smp_valid    = ($urandom % 2) == 0;
         if (r < 30) smp_data = SMP_W'($urandom);
         else smp_data = SMP_W'((base + int'($urandom % 5) - 2 < 0) ? 0 : base + int'($urandom % 5) - 2);
         clear_faults = ($urandom % 8) == 0;
         log_clear    = ($urandom % 60) == 0;
         wp_unlock    = ($urandom % 2) == 0;
         thr_wr_en    = ($urandom % 25) == 0;
         thr_wr_data  = 16'($urandom);
         ts_tick      = ($urandom % 2) == 0;
         log_rd_idx   = PTR_W'($urandom);
         if (($urandom % 20) == 0) alert_mask = ~alert_mask;
         cyc();
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule